// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits behind a CAN receiver and decides, for every identifier that the protocol logic has finished collecting, whether the frame belongs to this node and which message object owns it. It keeps a table of message objects. Each object holds an identifier, a flag for the 11-bit or 29-bit format, a direction (receive or transmit) and an enable bit. Two global don't-care masks apply: one for 11-bit frames and one for 29-bit frames. The incoming identifier is masked first and then compared against every enabled object of the same format.

A data frame can only land in a receive object. When it does, that object's receive flag is set. A remote frame can only land in a transmit object. When it does, that object's transmit-request flag is set, so that the transmit side can send the data frame in reply without software action. If several objects qualify, the lowest-numbered one wins. The result is reported as a one-cycle pulse together with the winning index, one clock after the identifier strobe. Flags stay set until a per-object clear bit removes them.

Configuration uses a single write port. A select field chooses the object table, the 11-bit mask or the 29-bit mask, and an index names the object.

Top module: `can_id_filter`

## Requirements
- R1: After reset all objects are disabled, both masks are zero, every receive and transmit-request flag is clear and `hit_vld` is low.
- R2: A write with `cfg_we` high and `cfg_sel` = 0 loads the object named by `cfg_idx` with `cfg_id`, `cfg_ext`, `cfg_tx` and `cfg_en`. An index of `NUM_OBJ` or above writes nothing. `cfg_sel` = 1 loads the 11-bit mask from `cfg_id[10:0]`, and `cfg_sel` = 2 loads the 29-bit mask from all of `cfg_id`.
- R3: An 11-bit frame (`frm_ext` = 0) compares only `frm_id[10:0]`, and its upper identifier bits have no effect. A 29-bit frame compares `frm_id[28:0]`. A mask bit of 1 makes that identifier bit don't-care for every object, and a mask bit of 0 requires equality.
- R4: An object takes part in matching only when it is enabled and its format flag equals `frm_ext`.
- R5: A data frame (`frm_rtr` = 0) can only match receive objects (`cfg_tx` = 0). A remote frame (`frm_rtr` = 1) can only match transmit objects (`cfg_tx` = 1).
- R6: When several objects match, `hit_idx` reports the lowest-numbered one.
- R7: `hit_vld` is a one-cycle pulse in the cycle after `frm_vld` when a match exists. Without a match it stays low and `hit_idx` keeps its previous value.
- R8: A matched data frame sets `rx_flag` bit `hit_idx`. A matched remote frame sets `txreq_flag` bit `hit_idx`. A frame sets at most one flag bit in total.
- R9: A flag stays set until its bit of `clr_rx` or `clr_tx` is high at a clock edge. If a set and a clear of the same bit meet in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 object, 1 11-bit mask, 2 29-bit mask |
| cfg_idx | input | IDX_W | Object index for object writes |
| cfg_id | input | ID_W | Identifier or mask value |
| cfg_ext | input | 1 | Object format: 1 = 29-bit |
| cfg_tx | input | 1 | Object direction: 1 = transmit |
| cfg_en | input | 1 | Object enable |
| frm_vld | input | 1 | Incoming identifier strobe |
| frm_id | input | ID_W | Incoming identifier |
| frm_ext | input | 1 | Incoming frame is 29-bit |
| frm_rtr | input | 1 | Incoming frame is a remote frame |
| clr_rx | input | NUM_OBJ | Per-object receive flag clear |
| clr_tx | input | NUM_OBJ | Per-object transmit-request clear |
| hit_vld | output | 1 | Match pulse |
| hit_idx | output | IDX_W | Index of the winning object |
| rx_flag | output | NUM_OBJ | Receive flags |
| txreq_flag | output | NUM_OBJ | Automatic reply request flags |

## Verification
A corrupted object entry or mask shows up one clock after the very next frame that touches it. Depending on the fault, that frame misses, reports a different winning index, or sets a flag in the wrong vector. A wrong priority order shows up only when two objects qualify at once, so the bench builds such overlaps deliberately and also drives a masked sweep that produces many of them. Flag state that fails to hold or to clear is visible on the flag vectors in the cycle after the clear or set edge.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int NUM_OBJ = 15,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  localparam int IDX_W  = $clog2(NUM_OBJ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic               cfg_ext,
  input  logic               cfg_tx,
  input  logic               cfg_en,
  input  logic               frm_vld,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_ext,
  input  logic               frm_rtr,
  input  logic [NUM_OBJ-1:0] clr_rx,
  input  logic [NUM_OBJ-1:0] clr_tx,
  output logic               hit_vld,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [NUM_OBJ-1:0] rx_flag,
  output logic [NUM_OBJ-1:0] txreq_flag
);
  localparam logic [IDX_W:0] OBJ_LIM = (IDX_W+1)'(NUM_OBJ);

  logic [ID_W-1:0]    obj_id [NUM_OBJ];
  logic [NUM_OBJ-1:0] obj_ext, obj_tx, obj_en;
  logic [STD_W-1:0]   std_mask;
  logic [ID_W-1:0]    ext_mask;

  logic [NUM_OBJ-1:0] cand;
  logic [IDX_W-1:0]   win_idx;
  logic               any_hit;
  logic [NUM_OBJ-1:0] win_bit, rx_set, tx_set;

  for (genvar i = 0; i < NUM_OBJ; i++) begin : g_cmp
    logic [ID_W-1:0]  ex_diff;
    logic [STD_W-1:0] sd_diff;
    assign ex_diff = (frm_id ^ obj_id[i]) & ~ext_mask;
    assign sd_diff = (frm_id[STD_W-1:0] ^ obj_id[i][STD_W-1:0]) & ~std_mask;
    assign cand[i] = obj_en[i] && (obj_ext[i] == frm_ext) && (obj_tx[i] == frm_rtr) &&
                     (frm_ext ? (ex_diff == '0) : (sd_diff == '0));
  end

  always_comb begin
    win_idx = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--)
      if (cand[i]) win_idx = IDX_W'(i);
  end

  assign any_hit = frm_vld && (cand != '0);
  assign win_bit = NUM_OBJ'(1) << win_idx;
  assign rx_set  = (any_hit && !frm_rtr) ? win_bit : '0;
  assign tx_set  = (any_hit &&  frm_rtr) ? win_bit : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OBJ; i++) obj_id[i] <= '0;
      obj_ext    <= '0;
      obj_tx     <= '0;
      obj_en     <= '0;
      std_mask   <= '0;
      ext_mask   <= '0;
      hit_vld    <= 1'b0;
      hit_idx    <= '0;
      rx_flag    <= '0;
      txreq_flag <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: if ({1'b0, cfg_idx} < OBJ_LIM) begin
            obj_id[cfg_idx]  <= cfg_id;
            obj_ext[cfg_idx] <= cfg_ext;
            obj_tx[cfg_idx]  <= cfg_tx;
            obj_en[cfg_idx]  <= cfg_en;
          end
          2'd1: std_mask <= cfg_id[STD_W-1:0];
          2'd2: ext_mask <= cfg_id;
          default: ;
        endcase
      end
      hit_vld <= any_hit;
      if (any_hit) hit_idx <= win_idx;
      rx_flag    <= (rx_flag & ~clr_rx) | rx_set;
      txreq_flag <= (txreq_flag & ~clr_tx) | tx_set;
    end
  end

  // R7
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |-> $past(frm_vld));

  // R6
  hit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |-> ({1'b0, hit_idx} < OBJ_LIM));

  // R8
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |-> (rx_flag[hit_idx] || txreq_flag[hit_idx]));

  // R8
  single_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rx_flag & ~$past(rx_flag)) + $countones(txreq_flag & ~$past(txreq_flag))) <= 1);

  // R9
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_vld) |-> ((rx_flag & $past(clr_rx)) == '0));

  // R9
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_vld) |-> ((txreq_flag & $past(clr_tx)) == '0));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_vld) |-> ((rx_flag & ~$past(rx_flag)) == '0 && (txreq_flag & ~$past(txreq_flag)) == '0));
endmodule

// File: tb/can_id_filter_tb_top.sv
module can_id_filter_tb_top;
  localparam int NOBJ = 15;
  localparam int IW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [28:0] cfg_id = '0;
  logic cfg_ext = 1'b0, cfg_tx = 1'b0, cfg_en = 1'b0;
  logic frm_vld = 1'b0;
  logic [28:0] frm_id = '0;
  logic frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [NOBJ-1:0] clr_rx = '0, clr_tx = '0;
  logic hit_vld;
  logic [IW-1:0] hit_idx;
  logic [NOBJ-1:0] rx_flag, txreq_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int last_idx = 0;

  logic [28:0] m_id [NOBJ];
  bit m_ext [NOBJ];
  bit m_tx [NOBJ];
  bit m_en [NOBJ];
  logic [10:0] m_smask = '0;
  logic [28:0] m_emask = '0;

  always #4 clk = ~clk;

  can_id_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_id(cfg_id), .cfg_ext(cfg_ext), .cfg_tx(cfg_tx), .cfg_en(cfg_en),
    .frm_vld(frm_vld), .frm_id(frm_id), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
    .clr_rx(clr_rx), .clr_tx(clr_tx), .hit_vld(hit_vld), .hit_idx(hit_idx),
    .rx_flag(rx_flag), .txreq_flag(txreq_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int exp_win(logic [28:0] id, bit ext, bit rtr);
    for (int i = 0; i < NOBJ; i++) begin
      if (m_en[i] && m_ext[i] == ext && m_tx[i] == rtr) begin
        if (ext && (((id ^ m_id[i]) & ~m_emask) == 29'd0)) return i;
        if (!ext && (((id[10:0] ^ m_id[i][10:0]) & ~m_smask) == 11'd0)) return i;
      end
    end
    return -1;
  endfunction

  task automatic wr_obj(input int idx, input logic [28:0] id, input bit ext, input bit tx, input bit en);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd0; cfg_idx = IW'(idx); cfg_id = id;
    cfg_ext = ext; cfg_tx = tx; cfg_en = en;
    @(negedge clk);
    cfg_we = 0;
    if (idx < NOBJ) begin
      m_id[idx] = id; m_ext[idx] = ext; m_tx[idx] = tx; m_en[idx] = en;
    end
  endtask

  task automatic wr_mask(input bit ext, input logic [28:0] val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = ext ? 2'd2 : 2'd1; cfg_id = val;
    @(negedge clk);
    cfg_we = 0;
    if (ext) m_emask = val; else m_smask = val[10:0];
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_rx = '1; clr_tx = '1;
    @(negedge clk);
    clr_rx = '0; clr_tx = '0;
  endtask

  task automatic send(input logic [28:0] id, input bit ext, input bit rtr, input string tag);
    int w;
    logic [NOBJ-1:0] erx, etx;
    w = exp_win(id, ext, rtr);
    @(negedge clk);
    frm_vld = 1; frm_id = id; frm_ext = ext; frm_rtr = rtr;
    @(negedge clk);
    frm_vld = 0;
    erx = (w >= 0 && !rtr) ? (NOBJ'(1) << w) : '0;
    etx = (w >= 0 &&  rtr) ? (NOBJ'(1) << w) : '0;
    chk(hit_vld == (w >= 0), tag, "R7 hit_vld", 64'(hit_vld), 64'(w >= 0));
    if (w >= 0) begin
      chk(hit_idx == IW'(w), tag, "R6 hit_idx", 64'(hit_idx), 64'(w));
      last_idx = w;
    end else begin
      chk(hit_idx == IW'(last_idx), tag, "R7 hit_idx held", 64'(hit_idx), 64'(last_idx));
    end
    chk(rx_flag == erx, tag, "R8 rx_flag", 64'(rx_flag), 64'(erx));
    chk(txreq_flag == etx, tag, "R8 txreq_flag", 64'(txreq_flag), 64'(etx));
    @(negedge clk);
    chk(hit_vld == 1'b0, tag, "R7 pulse width", 64'(hit_vld), 64'd0);
    clear_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < NOBJ; i++) begin
      m_id[i] = '0; m_ext[i] = 0; m_tx[i] = 0; m_en[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(hit_vld == 1'b0, "R1", "hit_vld", 64'(hit_vld), 64'd0);
    chk(rx_flag == '0, "R1", "rx_flag", 64'(rx_flag), 64'd0);
    chk(txreq_flag == '0, "R1", "txreq_flag", 64'(txreq_flag), 64'd0);
    send(29'd0, 0, 0, "R1 all objects disabled");
    send(29'd0, 1, 1, "R1 all objects disabled");

    for (int i = 0; i < NOBJ; i++) begin
      bit e = (i % 3 == 0);
      logic [28:0] id = e ? (29'h0123456 + 29'(i) * 29'h0012345) : (29'h100 + 29'(i) * 29'd37);
      wr_obj(i, id, e, (i % 2 == 1), (i != 13));
    end

    // R4 R5 sweep over every object, both formats, both frame types
    for (int i = 0; i < NOBJ; i++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++)
          send(m_id[i], bit'(e), bit'(r), "R5");

    // R4 disabled object
    send(m_id[13], m_ext[13], m_tx[13], "R4 disabled");
    // R3 upper bits of an 11-bit frame ignored
    send({18'h3FFFF, m_id[2][10:0]}, 0, 0, "R3 upper bits");
    // R2 out-of-range index write ignored
    wr_obj(15, 29'h0ABCDE, 1, 0, 1);
    send(29'h0ABCDE, 1, 0, "R2 index out of range");

    // R2 R6 mask write creates overlapping objects
    wr_mask(0, 29'h00F);
    wr_obj(4, m_id[2] ^ 29'h005, 0, 0, 1);
    send(m_id[4], 0, 0, "R6 lowest wins");
    send(m_id[2] ^ 29'h00A, 0, 0, "R2 mask bits");
    wr_mask(1, 29'h0000FF);
    wr_obj(9, m_id[3] ^ 29'h33, 1, 1, 1);
    send(m_id[9], 1, 1, "R6 lowest wins ext");

    // R3 masked random sweep
    for (int k = 0; k < 200; k++) begin
      int i = int'($urandom % NOBJ);
      logic [28:0] id = m_id[i] ^ 29'($urandom & 32'h3F);
      send(id, m_ext[i], m_tx[i], "R3 masked");
    end

    // R9 set beats clear in the same cycle, then clear works
    @(negedge clk);
    frm_vld = 1; frm_id = m_id[1]; frm_ext = m_ext[1]; frm_rtr = m_tx[1];
    clr_rx = '1; clr_tx = '1;
    @(negedge clk);
    frm_vld = 0; clr_rx = '0; clr_tx = '0;
    chk(txreq_flag == NOBJ'(2), "R9", "set wins over clear", 64'(txreq_flag), 64'd2);
    repeat (3) @(negedge clk);
    chk(txreq_flag == NOBJ'(2), "R9", "flag holds", 64'(txreq_flag), 64'd2);
    clr_tx = NOBJ'(1);
    @(negedge clk);
    clr_tx = '0;
    chk(txreq_flag == NOBJ'(2), "R9", "other clear bit no effect", 64'(txreq_flag), 64'd2);
    clr_tx = NOBJ'(2);
    @(negedge clk);
    clr_tx = '0;
    chk(txreq_flag == '0, "R9", "cleared", 64'(txreq_flag), 64'd0);

    summary();
  end
endmodule